// File: doc/BRIEF.md
# Host Port Pin Function Selector

This block decides, pin by pin, what each pad of a small parallel host port does. A control register and a request-mode flag together select one of three uses for each pin. A pin can carry a request from the core to the host, take in an acknowledge from the host, or act as general-purpose I/O set by a direction register and a data register. For request pins the control register also selects between actively driving the pad and open-drain drive. The strobe pads are turned into active-high strobes for the core, whichever pad polarity has been programmed.

The pads are numbered as follows. Pad 0 is the first shared request pin. Pad 1 is the second shared request/acknowledge pin. Pads 2 and up are strobes: pad 2 is the combined strobe, pad 3 the read strobe and pad 4 the write strobe. On the pads, requests and the acknowledge are active low. The register port is a single-cycle write with a combinational read. Every control and status pin is a plain level, and no port has a handshake. The request-mode flag is a level that comes from outside. Pin selection follows it in the same cycle.

Top module: `hpc_pinmux`

## Requirements
- R1: After reset the control, direction and data registers read 0. Every pad then has its output enable at 0, and strobe polarity bit 9 reads 0, which means active low.
- R2: While control bit 6 (host enable) is 0, every pad behaves as GPIO: pad_oe[i] equals direction bit i and pad_o[i] equals data bit i. All strobe outputs are 0 and host_ack is 0.
- R3: In single mode (dbl_req_mode=0), when bits 6 and 4 (request enable) are both 1, pad 0 carries host_req. When bit 4 is 0, pads 0 and 1 are GPIO.
- R4: In double mode (dbl_req_mode=1), when bits 6 and 4 are both 1, pad 0 carries host_treq and pad 1 carries host_rreq.
- R5: In single mode, pad 1 is an acknowledge input (pad_oe=0, pad_o=0) only when bits 6, 4 and 5 are all 1. In that case host_ack is the inverse of pad_in[1]. In every other case host_ack is 0.
- R6: In double mode, bit 5 has no effect on any output.
- R7: When bit 8 is 0, a pad carrying a request has pad_oe=1 and pad_o equal to the inverse of the request level.
- R8: When bit 8 is 1, a pad carrying a request has pad_o=0 and pad_oe equal to the request level.
- R9: While host enable is 1, the strobe pads have pad_oe=0. strobe[k] equals pad_in[2+k] when bit 9 is 1, and its inverse when bit 9 is 0.
- R10: A control register read returns bits 4, 5, 6, 8 and 9 as they were written. All other bits read 0, including reserved bit 7.
- R11: A data register read (address 2) returns, for bit i, the stored data bit when direction bit i is 1 and pad_in[i] when it is 0. The direction register is at address 1, and the control register is at address 0.
- R12: A change of dbl_req_mode alters pin roles in the same cycle, without any register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 direction, 2 data |
| wr_data | input | DW | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DW | Read data, combinational |
| dbl_req_mode | input | 1 | 1 selects double-request mode |
| host_req | input | 1 | Core request, single mode |
| host_treq | input | 1 | Core transmit request, double mode |
| host_rreq | input | 1 | Core receive request, double mode |
| host_ack | output | 1 | Acknowledge seen on pad 1, active high |
| strobe | output | NSTB | Normalised active-high strobes: combined, read, write |
| pad_in | input | NPIN | Sampled pad levels |
| pad_o | output | NPIN | Pad output values |
| pad_oe | output | NPIN | Pad output enables |

## Verification
The bench sweeps every combination of the five control bits against both request modes. For each combination it applies all eight request-level patterns and all 32 pad-input patterns. The host-enable half of the sweep separates GPIO fallback from host roles. Crossing request enable with acknowledge enable and mode separates the request, transmit/receive and acknowledge roles, and shows that acknowledge enable is ignored in double mode. Crossing the drive bit with the request levels separates push-pull from open-drain, crossing the polarity bit with the pad patterns exposes any strobe inversion error, and the register writes carry junk in the unused bits so that readback masking is visible.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam int B_REQ = 4;
  localparam int B_ACK = 5;
  localparam int B_HEN = 6;
  localparam int B_RSV = 7;
  localparam int B_OD  = 8;
  localparam int B_POL = 9;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DIR  = 2'd1;
  localparam logic [1:0] A_DAT  = 2'd2;
  typedef enum logic [2:0] {
    ROLE_GPIO, ROLE_REQ, ROLE_TREQ, ROLE_RREQ, ROLE_ACK, ROLE_STB
  } role_e;
endpackage

// File: rtl/hpc_regs.sv
module hpc_regs import hpc_pkg::*; #(
  parameter int DW   = 16,
  parameter int NPIN = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      rd_addr,
  input  logic [NPIN-1:0] pad_in,
  output logic [DW-1:0]   ctrl_q,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] dat_q,
  output logic [DW-1:0]   rd_data
);
  localparam logic [DW-1:0] CTRL_MASK = DW'((1 << B_REQ) | (1 << B_ACK) |
                                            (1 << B_HEN) | (1 << B_OD) | (1 << B_POL));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      dir_q  <= '0;
      dat_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl_q <= wr_data & CTRL_MASK;
        A_DIR:   dir_q  <= wr_data[NPIN-1:0];
        A_DAT:   dat_q  <= wr_data[NPIN-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data = ctrl_q;
      A_DIR:  rd_data[NPIN-1:0] = dir_q;
      A_DAT:  rd_data[NPIN-1:0] = (dir_q & dat_q) | (~dir_q & pad_in);
      default: rd_data = '0;
    endcase
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl_q == '0 && dir_q == '0 && dat_q == '0));
  assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_CTRL) |-> !rd_data[B_RSV]);
endmodule

// File: rtl/hpc_role_dec.sv
module hpc_role_dec import hpc_pkg::*; #(
  parameter int NSTB = 3,
  localparam int NPIN = NSTB + 2
) (
  input  logic              host_en,
  input  logic              req_en,
  input  logic              ack_en,
  input  logic              dbl,
  output role_e [NPIN-1:0]  role
);
  always_comb begin
    role = {NPIN{ROLE_GPIO}};
    if (host_en) begin
      if (req_en) role[0] = dbl ? ROLE_TREQ : ROLE_REQ;
      if (dbl) begin
        if (req_en) role[1] = ROLE_RREQ;
      end else if (req_en && ack_en) begin
        role[1] = ROLE_ACK;
      end
      for (int k = 2; k < NPIN; k++) role[k] = ROLE_STB;
    end
  end
endmodule

// File: rtl/hpc_pad_cell.sv
module hpc_pad_cell import hpc_pkg::*; (
  input  logic  clk,
  input  logic  rst,
  input  role_e role,
  input  logic  od,
  input  logic  dir,
  input  logic  dat,
  input  logic  req_i,
  input  logic  treq_i,
  input  logic  rreq_i,
  output logic  pad_o,
  output logic  pad_oe
);
  logic lvl;
  logic is_req;

  always_comb begin
    lvl    = 1'b0;
    is_req = 1'b0;
    case (role)
      ROLE_REQ:  begin lvl = req_i;  is_req = 1'b1; end
      ROLE_TREQ: begin lvl = treq_i; is_req = 1'b1; end
      ROLE_RREQ: begin lvl = rreq_i; is_req = 1'b1; end
      default:   ;
    endcase
  end

  always_comb begin
    if (is_req) begin
      pad_o  = od ? 1'b0 : ~lvl;
      pad_oe = od ? lvl : 1'b1;
    end else if (role == ROLE_GPIO) begin
      pad_o  = dat;
      pad_oe = dir;
    end else begin
      pad_o  = 1'b0;
      pad_oe = 1'b0;
    end
  end

  assert_od_low_R8: assert property (@(posedge clk) disable iff (rst)
    (is_req && od) |-> (pad_o == 1'b0));
  assert_pp_drive_R7: assert property (@(posedge clk) disable iff (rst)
    (is_req && !od) |-> pad_oe);
  assert_input_hiz_R5: assert property (@(posedge clk) disable iff (rst)
    (role == ROLE_ACK || role == ROLE_STB) |-> !pad_oe);
endmodule

// File: rtl/hpc_strobe_norm.sv
module hpc_strobe_norm #(
  parameter int NSTB = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            pol_high,
  input  logic [NSTB-1:0] pad_stb,
  output logic [NSTB-1:0] strobe
);
  assign strobe = en ? (pad_stb ^ {NSTB{~pol_high}}) : '0;

  assert_strobe_follow_R9: assert property (@(posedge clk) disable iff (rst)
    (en && pol_high) |-> (strobe == pad_stb));
  assert_strobe_off_R2: assert property (@(posedge clk) disable iff (rst)
    !en |-> (strobe == '0));
endmodule

// File: rtl/hpc_pinmux.sv
module hpc_pinmux import hpc_pkg::*; #(
  parameter int DW   = 16,
  parameter int NSTB = 3,
  localparam int NPIN = NSTB + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic            dbl_req_mode,
  input  logic            host_req,
  input  logic            host_treq,
  input  logic            host_rreq,
  output logic            host_ack,
  output logic [NSTB-1:0] strobe,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_o,
  output logic [NPIN-1:0] pad_oe
);
  logic [DW-1:0]   ctrl_q;
  logic [NPIN-1:0] dir_q;
  logic [NPIN-1:0] dat_q;
  role_e [NPIN-1:0] role;

  hpc_regs #(.DW(DW), .NPIN(NPIN)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .pad_in(pad_in), .ctrl_q(ctrl_q), .dir_q(dir_q),
    .dat_q(dat_q), .rd_data(rd_data)
  );

  hpc_role_dec #(.NSTB(NSTB)) dec_i (
    .host_en(ctrl_q[B_HEN]), .req_en(ctrl_q[B_REQ]), .ack_en(ctrl_q[B_ACK]),
    .dbl(dbl_req_mode), .role(role)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pad
    hpc_pad_cell cell_i (
      .clk(clk), .rst(rst), .role(role[i]), .od(ctrl_q[B_OD]),
      .dir(dir_q[i]), .dat(dat_q[i]), .req_i(host_req), .treq_i(host_treq),
      .rreq_i(host_rreq), .pad_o(pad_o[i]), .pad_oe(pad_oe[i])
    );
  end

  hpc_strobe_norm #(.NSTB(NSTB)) stb_i (
    .clk(clk), .rst(rst), .en(ctrl_q[B_HEN]), .pol_high(ctrl_q[B_POL]),
    .pad_stb(pad_in[NPIN-1:2]), .strobe(strobe)
  );

  assign host_ack = (role[1] == ROLE_ACK) & ~pad_in[1];

  assert_gpio_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[B_HEN] |-> (pad_oe == dir_q && pad_o == dat_q && !host_ack));
  assert_ack_dbl_R6: assert property (@(posedge clk) disable iff (rst)
    dbl_req_mode |-> !host_ack);
endmodule

// File: tb/hpc_pinmux_tb_top.sv
module hpc_pinmux_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NSTB = 3;
  localparam int NPIN = NSTB + 2;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [DW-1:0] wr_data = 0, rd_data;
  logic dbl = 0, rq = 0, tq = 0, rr = 0, ack;
  logic [NSTB-1:0] stb;
  logic [NPIN-1:0] pin = 0, po, poe;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpc_pinmux #(.DW(DW), .NSTB(NSTB)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dbl_req_mode(dbl), .host_req(rq),
    .host_treq(tq), .host_rreq(rr), .host_ack(ack), .strobe(stb),
    .pad_in(pin), .pad_o(po), .pad_oe(poe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // expected role codes: 0 gpio, 1 req, 2 treq, 3 rreq, 4 ack, 5 strobe
  function automatic int erole(int p, bit he, bit re, bit ae, bit d);
    if (!he) return 0;
    if (p == 0) return re ? (d ? 2 : 1) : 0;
    if (p == 1) return d ? (re ? 3 : 0) : ((re && ae) ? 4 : 0);
    return 5;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NPIN-1:0] dir, dat;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    rd_addr = 0; #1;
    chk("R1 ctrl", rd_data, 0);
    chk("R1 oe", poe, 0);
    rd_addr = 1; #1; chk("R1 dir", rd_data, 0);
    pin = 0; rd_addr = 2; #1; chk("R1 dat", rd_data, 0);

    for (int c = 0; c < 32; c++) begin
      bit re = c[0], ae = c[1], he = c[2], od = c[3], pol = c[4];
      logic [DW-1:0] cv;
      cv = DW'({pol, od, 1'b0, he, ae, re, 4'b0});
      dir = NPIN'(c * 7 + 3);
      dat = NPIN'(c * 13 + 5);
      wr(0, cv | 16'hFC8F);
      wr(1, DW'(dir));
      wr(2, DW'(dat));
      rd_addr = 0; #1;
      chk("R10 ctrl readback", rd_data, cv);
      for (int d = 0; d < 2; d++) begin
        for (int r = 0; r < 8; r++) begin
          for (int p = 0; p < 32; p++) begin
            dbl = d[0]; rq = r[0]; tq = r[1]; rr = r[2]; pin = NPIN'(p);
            rd_addr = 2; #1;
            chk("R11 data read", rd_data, DW'((dir & dat) | (~dir & pin)));
            for (int i = 0; i < NPIN; i++) begin
              int ro = erole(i, he, re, ae, d[0]);
              bit eo, eoe, lvl;
              string tag;
              lvl = (ro == 1) ? rq : (ro == 2) ? tq : rr;
              case (ro)
                0: begin eo = dat[i]; eoe = dir[i]; tag = he ? (d[0] ? "R6 gpio" : "R3 gpio") : "R2 gpio"; end
                1, 2, 3: begin
                  eo = od ? 1'b0 : ~lvl; eoe = od ? lvl : 1'b1;
                  tag = (ro == 1) ? (od ? "R3/R8" : "R3/R7") : (od ? "R4/R8" : "R4/R7");
                end
                4: begin eo = 0; eoe = 0; tag = "R5 ack pin"; end
                default: begin eo = 0; eoe = 0; tag = "R9 strobe pin"; end
              endcase
              chk(tag, {30'd0, po[i], poe[i]}, {30'd0, eo, eoe});
            end
            chk(d[0] ? "R6 ack" : "R5 ack", ack,
                (erole(1, he, re, ae, d[0]) == 4) ? ~pin[1] : 1'b0);
            chk(he ? "R9 strobe" : "R2 strobe", stb,
                he ? (pol ? pin[NPIN-1:2] : ~pin[NPIN-1:2]) : 0);
          end
        end
      end
    end

    // R12: mode flag change alone, no write in between
    wr(0, DW'((1 << 4) | (1 << 5) | (1 << 6)));
    rr = 1; pin = 0; dbl = 0; #1;
    chk("R12 single ack pin oe", poe[1], 0);
    chk("R12 single ack", ack, 1);
    dbl = 1; #1;
    chk("R12 double rreq oe", poe[1], 1);
    chk("R12 double rreq val", po[1], 0);
    dbl = 0; #1;
    chk("R12 back to single", poe[1], 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule